// File: doc/BRIEF.md
# Banked ROM Window Mapper

This block turns a CPU bus address (bank byte plus 16-bit offset) into a physical byte address for one of two ROMs: a large data ROM or a smaller program ROM. The low six bits of the bank and the offset form a 22-bit linear address. That address splits into four 1 MiB windows. Each window has its own 3-bit page register, which places it on any 1 MiB page of the data ROM. Windows 0 and 1 can instead be served from program ROM.

A size code limits the data ROM address space to 1, 2, 4 or 8 MiB. Addresses that land past the populated size of either ROM are folded back into it. The folding works for sizes that are not a power of two: a small state machine repeatedly removes the highest set address bit, one bit per clock.

A request is accepted while the block is idle. `busy` stays high while the address is being worked out. `done` pulses for one cycle when `physAddr`, `useProg` and `zeroData` are valid, and those outputs hold until the next result. Configuration is written through a byte-wide register port.

Top module: `rom_window_mapper`

## Requirements
- R1: Config writes: select 0 keeps bits 7 and 2:0, and bit 7 drives `sramEn`. Selects 1 to 3 keep bits 2:0 as the page of windows 1 to 3. Select 4 keeps bits 2:0, where bits 1:0 are the size code and bit 2 is the program-ROM-second-megabyte enable.
- R2: After reset the pages of windows 0 to 3 are 0, 0, 1 and 2. The size register is 0, `sramEn` is 0, and `busy`, `done` and `physAddr` are 0.
- R3: The linear address is {bank[5:0], offset}, so bank bits 7:6 are ignored. The window number is linear bits 21:20.
- R4: A data ROM access starts from address (page << 20) | linear[19:0].
- R5: A data ROM address is ANDed with (1 MiB << size code) − 1 before folding.
- R6: When the size code is not 3 and bit 22 of the data address is set, the result is `zeroData`=1 with `physAddr`=0.
- R7: When `progRomBytes` is nonzero, window 0 uses program ROM (`useProg`=1) at address linear[19:0]. When `progRomBytes` is zero, window 0 uses the data ROM.
- R8: Window 1 uses program ROM at 0x100000 + linear[19:0] only when size-register bit 2 is set and program ROM is present.
- R9: Folding: while the address is at least the ROM size, subtract the highest set bit of the address. If the size exceeds that bit, move the bit from the size into a base. The result is base + address.
- R10: A ROM size of 0 gives `physAddr`=0 with `zeroData`=1.
- R11: A request is taken only while `busy` is low. `done` is a single-cycle pulse with `busy` low. Outputs do not change while idle. A result arrives within 26 cycles of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Config register write strobe |
| cfgSel | input | 3 | Config register select (0 to 4) |
| cfgData | input | 8 | Config write data |
| progRomBytes | input | 24 | Populated program ROM size in bytes (0 = absent) |
| dataRomBytes | input | 24 | Populated data ROM size in bytes |
| reqValid | input | 1 | Start a translation |
| reqBank | input | 8 | CPU bank byte |
| reqOffset | input | 16 | CPU offset within the bank |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle result strobe |
| physAddr | output | 24 | Physical byte address |
| useProg | output | 1 | Result addresses program ROM |
| zeroData | output | 1 | Access returns zero |
| sramEn | output | 1 | Battery RAM enable from config bit 7 |

## Verification
The assertions check the handshake on every cycle: `done` is a lone pulse while idle, results hold between requests, and the busy period is bounded. They also check that every data or program ROM result falls below the populated size, and that a zero result carries address 0.

Only the bench scenarios can show the actual address arithmetic. These cover page selection, the reset page values, bank bits ignored, the size-code mask, the bit-22 cut-off, the program ROM choice for windows 0 and 1, and non-power-of-two folding. Register write masking is seen through `sramEn` and through the pages that later requests use.

// File: rtl/rom_window_pkg.sv
package rom_window_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mapState_e;
endpackage

// File: rtl/rom_window_ctrl.sv
module rom_window_ctrl
  import rom_window_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        stepNeeded,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  mapState_e state;

  always_comb begin
    strobes.load   = (state == ST_IDLE) && reqValid;
    strobes.step   = (state == ST_RUN) && stepNeeded;
    strobes.finish = (state == ST_RUN) && !stepNeeded;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strobes.finish;
      if (strobes.load)        state <= ST_RUN;
      else if (strobes.finish) state <= ST_IDLE;
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/rom_window_dp.sv
module rom_window_dp
  import rom_window_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PAGE_W    = 3,
  parameter int WIN_OFF_W = 20,
  parameter int NUM_WIN   = 4,
  parameter int BANK_W    = 8,
  parameter int OFF_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [7:0]        cfgData,
  input  logic [ADDR_W-1:0] progRomBytes,
  input  logic [ADDR_W-1:0] dataRomBytes,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [OFF_W-1:0]  reqOffset,
  input  ctlStrobes_t       strobes,
  output logic              stepNeeded,
  output logic [ADDR_W-1:0] physAddr,
  output logic              useProg,
  output logic              zeroData,
  output logic              sramEn
);
  localparam int WIN_W    = $clog2(NUM_WIN);
  localparam int LIN_W    = WIN_W + WIN_OFF_W;
  localparam int BANK_LO  = LIN_W - OFF_W;
  localparam int HIGH_BIT = WIN_OFF_W + 2;
  localparam int SIZE_SEL = NUM_WIN;

  // configuration registers
  logic [PAGE_W-1:0] pageReg [NUM_WIN];
  logic [2:0]        sizeReg;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_page
    localparam logic [PAGE_W-1:0] RST_PAGE = (w >= 2) ? PAGE_W'(w - 1) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        pageReg[w] <= RST_PAGE;
      else if (cfgWe && (cfgSel == 3'(w)))
        pageReg[w] <= cfgData[PAGE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sizeReg <= '0;
      sramEn  <= 1'b0;
    end else if (cfgWe) begin
      if (cfgSel == 3'(SIZE_SEL)) sizeReg <= cfgData[2:0];
      if (cfgSel == 3'd0)         sramEn  <= cfgData[7];
    end
  end

  // address decode for a new request
  logic [LIN_W-1:0]     linear;
  logic [WIN_W-1:0]     win;
  logic [WIN_OFF_W-1:0] lowOff;
  logic                 progPresent;
  logic                 pickProg;
  logic [ADDR_W-1:0]    progStart;
  logic [ADDR_W-1:0]    dataRaw;
  logic [ADDR_W-1:0]    dataMask;
  logic                 dataCut;
  logic [ADDR_W-1:0]    oneVal;

  always_comb begin
    linear      = {reqBank[BANK_LO-1:0], reqOffset};
    win         = linear[LIN_W-1:WIN_OFF_W];
    lowOff      = linear[WIN_OFF_W-1:0];
    progPresent = (progRomBytes != '0);
    pickProg    = progPresent && ((win == '0) || ((win == WIN_W'(1)) && sizeReg[2]));
    progStart   = ADDR_W'(lowOff);
    if (win == WIN_W'(1)) progStart[WIN_OFF_W] = 1'b1;
    dataRaw     = ADDR_W'({pageReg[win], lowOff});
    oneVal      = ADDR_W'(1);
    dataMask    = (oneVal << (WIN_OFF_W + int'(sizeReg[1:0]))) - oneVal;
    dataCut     = (sizeReg[1:0] != 2'd3) && dataRaw[HIGH_BIT];
  end

  // folding state
  logic [ADDR_W-1:0] curAddr, curSize, curBase, curTop;
  logic              curZero, curProg;

  function automatic logic [ADDR_W-1:0] topBit(input logic [ADDR_W-1:0] v);
    logic [ADDR_W-1:0] r;
    r = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (v[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  assign curTop     = topBit(curAddr);
  assign stepNeeded = !curZero && (curSize != '0) && (curAddr >= curSize);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curAddr  <= '0;
      curSize  <= '0;
      curBase  <= '0;
      curZero  <= 1'b0;
      curProg  <= 1'b0;
      physAddr <= '0;
      useProg  <= 1'b0;
      zeroData <= 1'b0;
    end else begin
      if (strobes.load) begin
        curBase <= '0;
        curProg <= pickProg;
        curZero <= !pickProg && dataCut;
        curAddr <= pickProg ? progStart : (dataRaw & dataMask);
        curSize <= pickProg ? progRomBytes : dataRomBytes;
      end
      if (strobes.step) begin
        curAddr <= curAddr - curTop;
        if (curSize > curTop) begin
          curSize <= curSize - curTop;
          curBase <= curBase + curTop;
        end
      end
      if (strobes.finish) begin
        useProg <= curProg;
        if (curZero || (curSize == '0)) begin
          physAddr <= '0;
          zeroData <= 1'b1;
        end else begin
          physAddr <= curBase + curAddr;
          zeroData <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rom_window_mapper.sv
module rom_window_mapper
  import rom_window_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int PAGE_W    = 3,
  parameter int WIN_OFF_W = 20,
  parameter int NUM_WIN   = 4,
  parameter int BANK_W    = 8,
  parameter int OFF_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [2:0]        cfgSel,
  input  logic [7:0]        cfgData,
  input  logic [ADDR_W-1:0] progRomBytes,
  input  logic [ADDR_W-1:0] dataRomBytes,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [OFF_W-1:0]  reqOffset,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] physAddr,
  output logic              useProg,
  output logic              zeroData,
  output logic              sramEn
);
  ctlStrobes_t strobes;
  logic        stepNeeded;

  rom_window_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .stepNeeded (stepNeeded),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done)
  );

  rom_window_dp #(
    .ADDR_W    (ADDR_W),
    .PAGE_W    (PAGE_W),
    .WIN_OFF_W (WIN_OFF_W),
    .NUM_WIN   (NUM_WIN),
    .BANK_W    (BANK_W),
    .OFF_W     (OFF_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfgWe        (cfgWe),
    .cfgSel       (cfgSel),
    .cfgData      (cfgData),
    .progRomBytes (progRomBytes),
    .dataRomBytes (dataRomBytes),
    .reqBank      (reqBank),
    .reqOffset    (reqOffset),
    .strobes      (strobes),
    .stepNeeded   (stepNeeded),
    .physAddr     (physAddr),
    .useProg      (useProg),
    .zeroData     (zeroData),
    .sramEn       (sramEn)
  );
endmodule

// File: rtl/rom_window_mapper_chk.sv
module rom_window_mapper_chk #(
  parameter int ADDR_W    = 24,
  parameter int MAX_CYCLES = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] physAddr,
  input logic              useProg,
  input logic              zeroData,
  input logic [ADDR_W-1:0] progRomBytes,
  input logic [ADDR_W-1:0] dataRomBytes
);
  logic [7:0] busyCount;

  always_ff @(posedge clk) begin
    if (!rst_n)    busyCount <= '0;
    else if (busy) busyCount <= busyCount + 8'd1;
    else           busyCount <= '0;
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(physAddr) && $stable(useProg) && $stable(zeroData));

  // R11
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busyCount <= 8'(MAX_CYCLES));

  // R6
  zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && zeroData) |-> (physAddr == '0));

  // R9
  data_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !useProg && !zeroData) |-> (physAddr < dataRomBytes));

  // R9
  prog_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && useProg && !zeroData) |-> (physAddr < progRomBytes));
endmodule

bind rom_window_mapper rom_window_mapper_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .physAddr     (physAddr),
  .useProg      (useProg),
  .zeroData     (zeroData),
  .progRomBytes (progRomBytes),
  .dataRomBytes (dataRomBytes)
);

// File: tb/rom_window_mapper_tb.sv
module rom_window_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgSel = '0;
  logic [7:0]  cfgData = '0;
  logic [23:0] progRomBytes = 24'h180000;
  logic [23:0] dataRomBytes = 24'h300000;
  logic        reqValid = 1'b0;
  logic [7:0]  reqBank = '0;
  logic [15:0] reqOffset = '0;
  logic        busy, done, useProg, zeroData, sramEn;
  logic [23:0] physAddr;

  int testsRun = 0;
  int testsFailed = 0;
  int lastLatency = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rom_window_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .progRomBytes(progRomBytes), .dataRomBytes(dataRomBytes),
    .reqValid(reqValid), .reqBank(reqBank), .reqOffset(reqOffset),
    .busy(busy), .done(done), .physAddr(physAddr), .useProg(useProg),
    .zeroData(zeroData), .sramEn(sramEn)
  );

  // {bank, offset, expected address, expected useProg, expected zeroData}
  localparam int NVEC = 6;
  localparam logic [49:0] VECS [NVEC] = '{
    {8'h00, 16'h8000, 24'h008000, 1'b1, 1'b0},  // R7 window 0 program ROM
    {8'h10, 16'h1234, 24'h001234, 1'b0, 1'b0},  // R4 window 1 page 0
    {8'h25, 16'hABCD, 24'h15ABCD, 1'b0, 1'b0},  // R2 window 2 page 1
    {8'h3F, 16'hFFFF, 24'h2FFFFF, 1'b0, 1'b0},  // R2 window 3 page 2
    {8'hC5, 16'h0010, 24'h050010, 1'b1, 1'b0},  // R3 bank bits 7:6 dropped
    {8'h0F, 16'hFFFF, 24'h0FFFFF, 1'b1, 1'b0}   // R7 top of window 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic translate(input logic [7:0] bank, input logic [15:0] off);
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqBank = bank; reqOffset = off;
    @(negedge clk);
    reqValid = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    lastLatency = n;
  endtask

  task automatic expectResult(input string req, input logic [23:0] a, input logic p, input logic z);
    check({req, " done"}, 32'(done), 32'd1);
    check({req, " physAddr"}, 32'(physAddr), 32'(a));
    check({req, " useProg"}, 32'(useProg), 32'(p));
    check({req, " zeroData"}, 32'(zeroData), 32'(z));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    check("R2 busy", 32'(busy), 32'd0);
    check("R2 done", 32'(done), 32'd0);
    check("R2 sramEn", 32'(sramEn), 32'd0);
    check("R2 physAddr", 32'(physAddr), 32'd0);

    // R5 size code 2 for the vector table
    writeCfg(3'd4, 8'h02);
    for (int i = 0; i < NVEC; i++) begin
      translate(VECS[i][49:42], VECS[i][41:26]);
      expectResult($sformatf("R4/vec%0d", i), VECS[i][25:2], VECS[i][1], VECS[i][0]);
    end

    // R11 single pulse, idle hold
    @(negedge clk);
    check("R11 done one cycle", 32'(done), 32'd0);
    check("R11 hold physAddr", 32'(physAddr), 32'h0FFFFF);

    // R9 fold non-power-of-two data ROM (3 MiB)
    writeCfg(3'd3, 8'h03);
    translate(8'h34, 16'h5678);
    expectResult("R9 data fold", 24'h245678, 1'b0, 1'b0);
    check("R11 latency", 32'(lastLatency <= 27), 32'd1);

    // R5 size code 1 masks to 2 MiB
    writeCfg(3'd4, 8'h01);
    translate(8'h34, 16'h5678);
    expectResult("R5 mask", 24'h145678, 1'b0, 1'b0);

    // R6 bit 22 with code 2 gives zero
    writeCfg(3'd2, 8'h04);
    writeCfg(3'd4, 8'h02);
    translate(8'h25, 16'hABCD);
    expectResult("R6 cutoff", 24'h000000, 1'b0, 1'b1);

    // R5/R9 code 3 keeps bit 22 and folds it away
    writeCfg(3'd4, 8'h03);
    translate(8'h25, 16'hABCD);
    expectResult("R9 code3 fold", 24'h05ABCD, 1'b0, 1'b0);

    // R8 window 1 program ROM second megabyte, folded to 1.5 MiB
    writeCfg(3'd4, 8'h06);
    translate(8'h18, 16'h0000);
    expectResult("R8 prog window1", 24'h100000, 1'b1, 1'b0);

    // R10 data ROM size zero
    writeCfg(3'd4, 8'h02);
    dataRomBytes = 24'h000000;
    translate(8'h10, 16'h4444);
    expectResult("R10 size zero", 24'h000000, 1'b0, 1'b1);

    // R1 register masking; R7 program ROM absent
    dataRomBytes = 24'h800000;
    progRomBytes = 24'h000000;
    writeCfg(3'd0, 8'hFF);
    check("R1 sramEn set", 32'(sramEn), 32'd1);
    writeCfg(3'd4, 8'hFF);
    translate(8'h00, 16'h1234);
    expectResult("R1 page mask", 24'h701234, 1'b0, 1'b0);
    writeCfg(3'd0, 8'h05);
    check("R1 sramEn clear", 32'(sramEn), 32'd0);
    translate(8'h00, 16'h0001);
    expectResult("R1 page5", 24'h500001, 1'b0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule